// File: doc/BRIEF.md
# Cutset-Pipelined Three-Tap FIR Filter

This block is a single-channel three-tap finite impulse response filter with coefficients fixed at elaboration. It accepts one signed sample per clock, qualified by an input valid flag. It produces the weighted sum of the current sample and the two previous valid samples: y(n) = a·x(n) + b·x(n-1) + c·x(n-2).

A single register stage cuts the arithmetic. One register holds the product of the newest sample. The other holds the partial sum of the two older products. No register-to-register path carries more than one multiplier and one adder. The final adder works from those two registers alone. Products and sums keep full precision. A parameterised window of the full-precision result forms the output. A valid flag travels in step with the data. While the input valid flag is low, the delay line and the pipeline registers hold their contents.

Top module: `fir3_cutset_fir`

## Requirements
- R1: For every accepted sample x(n), the output equals a·x(n) + b·x(n-1) + c·x(n-2). Here x(n-1) and x(n-2) are the two previously accepted samples, counting only cycles with in_valid high.
- R2: When in_valid is high in a cycle, out_valid is high in the following cycle. In that same cycle out_data carries the result for that sample, a latency of one clock.
- R3: When in_valid is low in a cycle, out_valid is low in the following cycle.
- R4: A cycle with in_valid low has no effect on the filter. out_data keeps its previous value, and the next accepted sample is combined with the last two accepted samples, with no zeros inserted for the gap.
- R5: A synchronous active-high rst forces out_valid and out_data to zero on the next clock edge. It also clears the sample history, so the first samples after reset see zero for the missing history.
- R6: The sum is formed at full precision, W+CW+2 bits, with no internal wrap. out_data is bits [SHIFT+OW-1:SHIFT] of that two's-complement sum. This holds also at the most negative and most positive input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as a sample to accept |
| in_data | input | W | Signed two's-complement input sample |
| out_valid | output | 1 | Marks out_data as a freshly computed result |
| out_data | output | OW | Signed output, truncated window of the full-precision sum |

## Verification
The bench uses 4-bit samples and 4-bit coefficients of mixed sign. It streams every ordered triple of sample values back to back, so every combination of current and delayed operands reaches all three products; this separates a swapped, dropped or mis-delayed tap. A second stream inserts irregular gaps in the valid flag. It shows whether idle cycles wrongly shift zeros or stale values into the history, and whether out_valid and out_data track the gaps. Runs of the extreme values -8 and 7 test the sign handling and the truncation window. Resets at the start and in mid-stream, each followed by fresh samples, show whether the history is really cleared.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

   // Number of coefficients in the filter.
   localparam int NUM_TAPS = 3;

   // Width of a signed product of a w-bit sample and a cw-bit coefficient.
   function automatic int prod_w(input int w, input int cw);
      return w + cw;
   endfunction

   // Width that holds the sum of `terms` such products without wrap.
   function automatic int acc_w(input int w, input int cw, input int terms);
      return w + cw + $clog2(terms);
   endfunction

endpackage

// File: rtl/fir3_delay_line.sv
module fir3_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      adv,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   taps
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("fir3_delay_line: DEPTH must be at least 1");
      end
   endgenerate

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
         logic [W-1:0] feed;
         if (g == 0) begin : g_head
            assign feed = din;
         end else begin : g_body
            assign feed = taps[g-1];
         end
         always_ff @(posedge clk) begin
            if (rst) begin
               taps[g] <= '0;
            end else if (adv) begin
               taps[g] <= feed;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fir3_cutset_stage.sv
module fir3_cutset_stage #(
   parameter int                    W      = 8,
   parameter int                    CW     = 8,
   parameter int                    FW     = 18,
   parameter logic signed [CW-1:0]  COEF_A = 1,
   parameter logic signed [CW-1:0]  COEF_B = 1,
   parameter logic signed [CW-1:0]  COEF_C = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  adv,
   input  logic signed [W-1:0]   x_now,
   input  logic signed [W-1:0]   x_d1,
   input  logic signed [W-1:0]   x_d2,
   output logic signed [FW-1:0]  lead_q,
   output logic signed [FW-1:0]  tail_q
);

   localparam int PW  = fir3_pkg::prod_w(W, CW);
   localparam int EXT = FW - PW;

   generate
      if (EXT < 1) begin : g_bad_width
         $error("fir3_cutset_stage: FW must exceed the product width");
      end
   endgenerate

   logic signed [PW-1:0] prod_a;
   logic signed [PW-1:0] prod_b;
   logic signed [PW-1:0] prod_c;
   logic signed [FW-1:0] ext_a;
   logic signed [FW-1:0] ext_b;
   logic signed [FW-1:0] ext_c;
   logic signed [FW-1:0] tail_d;

   // Multipliers: both operands sign-extended to the product width.
   assign prod_a = PW'(COEF_A) * PW'(x_now);
   assign prod_b = PW'(COEF_B) * PW'(x_d1);
   assign prod_c = PW'(COEF_C) * PW'(x_d2);

   assign ext_a = {{EXT{prod_a[PW-1]}}, prod_a};
   assign ext_b = {{EXT{prod_b[PW-1]}}, prod_b};
   assign ext_c = {{EXT{prod_c[PW-1]}}, prod_c};

   // One adder after the older two multipliers; the newest product
   // reaches the cutset with no adder in front of it.
   assign tail_d = ext_b + ext_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         lead_q <= '0;
         tail_q <= '0;
      end else if (adv) begin
         lead_q <= ext_a;
         tail_q <= tail_d;
      end
   end

endmodule

// File: rtl/fir3_cutset_fir.sv
module fir3_cutset_fir #(
   parameter int                    W      = 8,
   parameter int                    CW     = 8,
   parameter logic signed [CW-1:0]  COEF_A = 8'sd3,
   parameter logic signed [CW-1:0]  COEF_B = -8'sd5,
   parameter logic signed [CW-1:0]  COEF_C = 8'sd7,
   parameter int                    OW     = 16,
   parameter int                    SHIFT  = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic signed [W-1:0]   in_data,
   output logic                  out_valid,
   output logic signed [OW-1:0]  out_data
);

   localparam int FW    = fir3_pkg::acc_w(W, CW, fir3_pkg::NUM_TAPS);
   localparam int DEPTH = fir3_pkg::NUM_TAPS - 1;

   generate
      if (W < 2 || CW < 2) begin : g_bad_operands
         $error("fir3_cutset_fir: W and CW must be at least 2");
      end
      if (OW < 1 || SHIFT < 0 || OW + SHIFT > FW) begin : g_bad_window
         $error("fir3_cutset_fir: output window exceeds the full-precision sum");
      end
   endgenerate

   logic [DEPTH-1:0][W-1:0] hist;
   logic signed [FW-1:0]    lead_q;
   logic signed [FW-1:0]    tail_q;
   logic signed [FW-1:0]    sum_full;
   logic                    vld_q;

   fir3_delay_line #(
      .W     (W),
      .DEPTH (DEPTH)
   ) u_taps (
      .clk  (clk),
      .rst  (rst),
      .adv  (in_valid),
      .din  (in_data),
      .taps (hist)
   );

   fir3_cutset_stage #(
      .W      (W),
      .CW     (CW),
      .FW     (FW),
      .COEF_A (COEF_A),
      .COEF_B (COEF_B),
      .COEF_C (COEF_C)
   ) u_cut (
      .clk    (clk),
      .rst    (rst),
      .adv    (in_valid),
      .x_now  (in_data),
      .x_d1   ($signed(hist[0])),
      .x_d2   ($signed(hist[DEPTH-1])),
      .lead_q (lead_q),
      .tail_q (tail_q)
   );

   // Valid flag crosses the same cutset as the data.
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
      end
   end

   // Single adder after the cutset.
   assign sum_full  = lead_q + tail_q;
   assign out_data  = sum_full[SHIFT +: OW];
   assign out_valid = vld_q;

   logic unused_sum;
   assign unused_sum = ^sum_full;

endmodule

// File: rtl/fir3_cutset_chk.sv
module fir3_cutset_chk #(
   parameter int OW = 16
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic           out_valid,
   input logic [OW-1:0]  out_data
);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                   // R2

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                                 // R3

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));                          // R4

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));                   // R5

endmodule

bind fir3_cutset_fir fir3_cutset_chk #(.OW(OW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_fir3_cutset_fir.sv
`timescale 1ns/1ps
module sim_fir3_cutset_fir;

   localparam int W     = 4;
   localparam int CW    = 4;
   localparam int CA    = 3;
   localparam int CB    = -5;
   localparam int CC    = 7;
   localparam int OW    = 6;
   localparam int SHIFT = 2;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [W-1:0]  in_data = '0;
   logic                 out_valid;
   logic signed [OW-1:0] out_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Bench model state
   int          h1 = 0;
   int          h2 = 0;
   logic [OW-1:0] exp_data = '0;
   logic        exp_valid = 1'b0;
   bit          pend = 1'b0;
   string       pend_tag = "R1";

   always #2.5 clk = ~clk;

   fir3_cutset_fir #(
      .W      (W),
      .CW     (CW),
      .COEF_A (4'(CA)),
      .COEF_B (4'(CB)),
      .COEF_C (4'(CC)),
      .OW     (OW),
      .SHIFT  (SHIFT)
   ) u0 (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Compare outputs produced by the previous drive (called at a negedge).
   task automatic settle();
      if (pend) begin
         chk(exp_valid ? "R2" : "R3", {31'b0, out_valid}, {31'b0, exp_valid});
         chk(pend_tag, {26'b0, out_data}, {26'b0, exp_data});
      end
   endtask

   task automatic step(input bit v, input int x, input string tag);
      int sx;
      logic [31:0] fv;
      @(negedge clk);
      settle();
      in_valid = v;
      in_data  = 4'(x);
      sx = int'($signed(4'(x)));
      if (v) begin
         fv = 32'(CA * sx + CB * h1 + CC * h2);
         exp_data = fv[SHIFT +: OW];
         h2 = h1;
         h1 = sx;
      end
      exp_valid = v;
      pend_tag  = v ? tag : "R4";
      pend      = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      settle();
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      pend = 1'b0;
      h1 = 0;
      h2 = 0;
      exp_data = '0;
      exp_valid = 1'b0;
      chk("R5", {31'b0, out_valid}, 32'd0);
      chk("R5", {26'b0, out_data}, 32'd0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      do_reset();
      // R5: first samples after reset see zero history
      step(1'b1, 5, "R5");
      step(1'b1, -3, "R5");
      step(1'b1, 7, "R1");
      // R1: every ordered triple streamed back to back
      for (int i = 0; i < 4096; i++) begin
         step(1'b1, (i >> 8) & 15, "R1");
         step(1'b1, (i >> 4) & 15, "R1");
         step(1'b1, i & 15, "R1");
      end
      // R4: irregular valid gaps, history must skip idle cycles
      for (int i = 0; i < 600; i++) begin
         bit v = ((i % 3) != 0) && ((i % 7) != 5);
         step(v, (i * 7 + (i >> 3)) & 15, "R4");
      end
      // R6: extreme values in every combination
      for (int i = 0; i < 8; i++) begin
         step(1'b1, i[2] ? -8 : 7, "R6");
         step(1'b1, i[1] ? -8 : 7, "R6");
         step(1'b1, i[0] ? -8 : 7, "R6");
      end
      step(1'b1, -8, "R6");
      step(1'b1, -8, "R6");
      step(1'b1, -8, "R6");
      step(1'b1, 7, "R6");
      // R5: mid-stream reset clears history
      do_reset();
      step(1'b1, -8, "R5");
      step(1'b0, 3, "R4");
      step(1'b1, 6, "R5");
      step(1'b1, 1, "R1");
      step(1'b0, 0, "R4");
      @(negedge clk);
      settle();
      pend = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule